// File: doc/BRIEF.md
# Compressed Instruction Expander

This combinational unit sits between instruction fetch and the main decoder of a 32-bit RISC-V integer core. It looks at the two lowest bits of the fetched word. When they are `11` the word is already a full-length instruction and goes through untouched. Any other value marks the low half-word as a 16-bit compressed instruction. The unit rewrites that half-word into the 32-bit base instruction that has the same effect. The downstream decoder then only has to handle one instruction format.

Three outputs come back: the 32-bit word, a flag that says the input was compressed, and an illegal flag. The illegal flag is raised for reserved code points, for unsupported floating-point or 64-bit-only forms, and for the all-zero half-word. Decoding gives strict precedence to the rs2 field (bits 6:2) over the rd field (bits 11:7) in the register-move/jump groups. Hint encodings are turned into the matching base-ISA hint and are not flagged. When the illegal flag is high, the expanded word carries no meaning.

Top module: `rvc_expander`

## Requirements
- R1: When instr_i[1:0] is 11, instr_o equals instr_i, is_compressed_o is 0 and illegal_o is 0.
- R2: When instr_i[1:0] is not 11, is_compressed_o is 1. Every legal expansion has instr_o[1:0] equal to 11.
- R3: In quadrant 10 with bits [15:12] = 1000, a nonzero bits [6:2] gives add rd, x0, rs2 (opcode 0110011). Zero bits [6:2] give jalr x0, 0(rs1) (opcode 1100111), with rs1 taken from bits [11:7].
- R4: The jump-register form with rs1 = x0 (half-word 0x8002) is illegal.
- R5: In quadrant 10 with bits [15:12] = 1001, a nonzero rs2 gives add rd, rd, rs2. Zero rs2 with rs1 = x0 gives ebreak (0x00100073). Zero rs2 with nonzero rs1 gives jalr x1, 0(rs1).
- R6: The move and add forms with nonzero rs2 and rd = x0 are legal and expand to add writing x0.
- R7: Hint forms of load-immediate (rd = x0), load-upper (rd = x0), the logical and arithmetic right shifts, and the left shift (shift amount 0 or rd = x0) expand to the corresponding base OP-IMM/LUI instruction and are legal.
- R8: The all-zero half-word, and the stack-pointer add-immediate in quadrant 00 with funct3 000 and zero immediate, are illegal.
- R9: Shift forms with bit 12 set are illegal. The stack-adjust form (quadrant 01, funct3 011, rd = x2) and load-upper (quadrant 01, funct3 011, rd ≠ x2) with a zero immediate are illegal.
- R10: 3-bit register fields select x8..x15, formed as {2'b01, field}.
- R11: Jump (quadrant 01, funct3 001/101) and branch-on-zero (funct3 110/111) offsets are reassembled from the scrambled bits and sign-extended from bit 12 of the half-word.
- R12: Quadrant 00 with funct3 001, 011, 100, 101 or 111, quadrant 10 with funct3 001, 011, 101 or 111, the quadrant 01 register-register group with bit 12 set, and stack-relative load with rd = x0 are all illegal.
- R13: Word loads and stores, both register-based and stack-relative, expand to lw/sw with zero-extended offsets scaled by 4. The stack-relative forms use x2 as the base register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Fetched instruction word |
| instr_o | output | 32 | Expanded or passed-through instruction |
| is_compressed_o | output | 1 | High when instr_i[1:0] is not 11 |
| illegal_o | output | 1 | High for reserved or unsupported compressed encodings |

## Verification
The checks assume a fully driven input word with no X or Z bits. The block holds no state, so the checks also assume each output is judged only after the input has settled. The bench drives instr_i at one clock edge and samples at the opposite edge. Every input it applies is a defined 32-bit value. Random half-words are drawn over all three compressed quadrants and the full-length space. Extra weight goes to the rs2/rd precedence group, so that zero and nonzero register fields both show up often.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
  localparam int unsigned ILEN = 32;
  localparam int unsigned CLEN = 16;

  localparam logic [6:0] OPC_LOAD   = 7'h03;
  localparam logic [6:0] OPC_OP_IMM = 7'h13;
  localparam logic [6:0] OPC_STORE  = 7'h23;
  localparam logic [6:0] OPC_OP     = 7'h33;
  localparam logic [6:0] OPC_LUI    = 7'h37;
  localparam logic [6:0] OPC_BRANCH = 7'h63;
  localparam logic [6:0] OPC_JALR   = 7'h67;
  localparam logic [6:0] OPC_JAL    = 7'h6f;

  localparam logic [ILEN-1:0] INSTR_EBREAK = 32'h0010_0073;

  typedef struct packed {
    logic [ILEN-1:0] word;
    logic            ill;
  } exp_t;

  function automatic logic [4:0] creg(input logic [2:0] r);
    return {2'b01, r};
  endfunction
endpackage

// File: rtl/rvc_quad0.sv
module rvc_quad0
  import rvc_pkg::*;
(
  input  logic [15:2] c_i,
  output exp_t        res_o
);
  logic [9:0] spn_imm;
  logic [6:0] w_off;

  assign spn_imm = {c_i[10:7], c_i[12:11], c_i[5], c_i[6], 2'b00};
  assign w_off   = {c_i[5], c_i[12:10], c_i[6], 2'b00};

  always_comb begin
    res_o.word = '0;
    res_o.ill  = 1'b0;
    unique case (c_i[15:13])
      3'b000: begin
        res_o.word = {2'b00, spn_imm, 5'd2, 3'b000, creg(c_i[4:2]), OPC_OP_IMM};
        res_o.ill  = (c_i[12:5] == 8'h00);
      end
      3'b010: res_o.word = {5'b0, w_off, creg(c_i[9:7]), 3'b010, creg(c_i[4:2]), OPC_LOAD};
      3'b110: res_o.word = {5'b0, w_off[6:5], creg(c_i[4:2]), creg(c_i[9:7]), 3'b010,
                            w_off[4:0], OPC_STORE};
      default: res_o.ill = 1'b1;
    endcase
  end
endmodule

// File: rtl/rvc_quad1.sv
module rvc_quad1
  import rvc_pkg::*;
(
  input  logic [15:2] c_i,
  output exp_t        res_o
);
  logic        s;
  logic [4:0]  rd;
  logic [4:0]  rdp;
  logic [4:0]  rs2p;
  logic [11:0] imm6_sx;
  logic [19:0] jal_fld;
  logic [11:0] sp_imm;

  assign s       = c_i[12];
  assign rd      = c_i[11:7];
  assign rdp     = creg(c_i[9:7]);
  assign rs2p    = creg(c_i[4:2]);
  assign imm6_sx = {{6{s}}, s, c_i[6:2]};
  assign jal_fld = {s, c_i[8], c_i[10:9], c_i[6], c_i[7], c_i[2], c_i[11], c_i[5:3],
                    s, {8{s}}};
  assign sp_imm  = {{3{s}}, c_i[4:3], c_i[5], c_i[2], c_i[6], 4'b0000};

  always_comb begin
    res_o.word = '0;
    res_o.ill  = 1'b0;
    unique case (c_i[15:13])
      3'b000: res_o.word = {imm6_sx, rd, 3'b000, rd, OPC_OP_IMM};
      3'b001: res_o.word = {jal_fld, 5'd1, OPC_JAL};
      3'b010: res_o.word = {imm6_sx, 5'd0, 3'b000, rd, OPC_OP_IMM};
      3'b011: begin
        if (rd == 5'd2) begin
          res_o.word = {sp_imm, 5'd2, 3'b000, 5'd2, OPC_OP_IMM};
        end else begin
          res_o.word = {{14{s}}, s, c_i[6:2], rd, OPC_LUI};
        end
        res_o.ill = ({s, c_i[6:2]} == 6'd0);
      end
      3'b100: begin
        unique case (c_i[11:10])
          2'b00: begin
            res_o.word = {7'b0000000, c_i[6:2], rdp, 3'b101, rdp, OPC_OP_IMM};
            res_o.ill  = s;
          end
          2'b01: begin
            res_o.word = {7'b0100000, c_i[6:2], rdp, 3'b101, rdp, OPC_OP_IMM};
            res_o.ill  = s;
          end
          2'b10: res_o.word = {imm6_sx, rdp, 3'b111, rdp, OPC_OP_IMM};
          default: begin
            unique case (c_i[6:5])
              2'b00:   res_o.word = {7'b0100000, rs2p, rdp, 3'b000, rdp, OPC_OP};
              2'b01:   res_o.word = {7'b0000000, rs2p, rdp, 3'b100, rdp, OPC_OP};
              2'b10:   res_o.word = {7'b0000000, rs2p, rdp, 3'b110, rdp, OPC_OP};
              default: res_o.word = {7'b0000000, rs2p, rdp, 3'b111, rdp, OPC_OP};
            endcase
            res_o.ill = s;
          end
        endcase
      end
      3'b101: res_o.word = {jal_fld, 5'd0, OPC_JAL};
      default: begin
        // branch on zero: funct3 110 eq, 111 ne
        res_o.word = {s, s, s, s, c_i[6:5], c_i[2], 5'd0, rdp, 2'b00, c_i[13],
                      c_i[11:10], c_i[4:3], s, OPC_BRANCH};
      end
    endcase
  end
endmodule

// File: rtl/rvc_quad2.sv
module rvc_quad2
  import rvc_pkg::*;
(
  input  logic [15:2] c_i,
  output exp_t        res_o
);
  logic [4:0] rd;
  logic [4:0] rs2;
  logic [7:0] lsp_off;
  logic [7:0] ssp_off;

  assign rd      = c_i[11:7];
  assign rs2     = c_i[6:2];
  assign lsp_off = {c_i[3:2], c_i[12], c_i[6:4], 2'b00};
  assign ssp_off = {c_i[8:7], c_i[12:9], 2'b00};

  always_comb begin
    res_o.word = '0;
    res_o.ill  = 1'b0;
    unique case (c_i[15:13])
      3'b000: begin
        res_o.word = {7'b0000000, rs2, rd, 3'b001, rd, OPC_OP_IMM};
        res_o.ill  = c_i[12];
      end
      3'b010: begin
        res_o.word = {4'b0, lsp_off, 5'd2, 3'b010, rd, OPC_LOAD};
        res_o.ill  = (rd == 5'd0);
      end
      3'b100: begin
        // rs2 decides before rd
        if (rs2 != 5'd0) begin
          res_o.word = {7'b0, rs2, (c_i[12] ? rd : 5'd0), 3'b000, rd, OPC_OP};
        end else if (!c_i[12]) begin
          res_o.word = {12'b0, rd, 3'b000, 5'd0, OPC_JALR};
          res_o.ill  = (rd == 5'd0);
        end else if (rd == 5'd0) begin
          res_o.word = INSTR_EBREAK;
        end else begin
          res_o.word = {12'b0, rd, 3'b000, 5'd1, OPC_JALR};
        end
      end
      3'b110: res_o.word = {4'b0, ssp_off[7:5], rs2, 5'd2, 3'b010, ssp_off[4:0], OPC_STORE};
      default: res_o.ill = 1'b1;
    endcase
  end
endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
  import rvc_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic [31:0] instr_o,
  output logic        is_compressed_o,
  output logic        illegal_o
);
  exp_t q_res [3];

  rvc_quad0 u_q0 (.c_i(instr_i[15:2]), .res_o(q_res[0]));
  rvc_quad1 u_q1 (.c_i(instr_i[15:2]), .res_o(q_res[1]));
  rvc_quad2 u_q2 (.c_i(instr_i[15:2]), .res_o(q_res[2]));

  always_comb begin
    unique case (instr_i[1:0])
      2'b00: begin
        instr_o   = q_res[0].word;
        illegal_o = q_res[0].ill;
      end
      2'b01: begin
        instr_o   = q_res[1].word;
        illegal_o = q_res[1].ill;
      end
      2'b10: begin
        instr_o   = q_res[2].word;
        illegal_o = q_res[2].ill;
      end
      default: begin
        instr_o   = instr_i;
        illegal_o = 1'b0;
      end
    endcase
  end

  assign is_compressed_o = (instr_i[1:0] != 2'b11);
endmodule

// File: rtl/rvc_expander_chk.sv
module rvc_expander_chk (
  input logic [31:0] instr_i,
  input logic [31:0] instr_o,
  input logic        is_compressed_o,
  input logic        illegal_o
);
  always_comb begin
    if (instr_i[1:0] == 2'b11) begin
      p_passthru_r1: assert (instr_o == instr_i && !is_compressed_o && !illegal_o);
    end
    if (is_compressed_o && !illegal_o) begin
      p_legal_low_r2: assert (instr_o[1:0] == 2'b11);
    end
    if (illegal_o) begin
      p_ill_needs_c_r2: assert (is_compressed_o);
    end
    if (instr_i[15:0] == 16'h8002) begin
      p_jr_zero_r4: assert (illegal_o);
    end
    if (instr_i[1:0] == 2'b10 && instr_i[15:13] == 3'b100 && instr_i[6:2] != 5'd0) begin
      p_rs2_first_r6: assert (!illegal_o && instr_o[6:0] == 7'h33);
    end
    if (instr_i[15:0] == 16'h0000) begin
      p_zero_word_r8: assert (illegal_o);
    end
  end
endmodule

bind rvc_expander rvc_expander_chk u_chk (.*);

// File: tb/sim_rvc_expander.sv
module sim_rvc_expander;
  logic        clk = 1'b0;
  logic [31:0] instr_i = 32'h0000_0013;
  logic [31:0] instr_o;
  logic        is_compressed_o;
  logic        illegal_o;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  rvc_expander u0 (.instr_i(instr_i), .instr_o(instr_o),
                   .is_compressed_o(is_compressed_o), .illegal_o(illegal_o));

  function automatic logic [31:0] e_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                      logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] e_i(logic [31:0] imm, logic [4:0] rs1, logic [2:0] f3,
                                      logic [4:0] rd, logic [6:0] op);
    return {imm[11:0], rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] e_s(logic [31:0] imm, logic [4:0] rs2, logic [4:0] rs1);
    return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], 7'h23};
  endfunction
  function automatic logic [31:0] e_b(logic [31:0] imm, logic [4:0] rs1, logic [2:0] f3);
    return {imm[12], imm[10:5], 5'd0, rs1, f3, imm[4:1], imm[11], 7'h63};
  endfunction
  function automatic logic [31:0] e_j(logic [31:0] imm, logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'h6f};
  endfunction

  // reference model: returns {illegal, word}
  function automatic logic [32:0] model(logic [31:0] w);
    logic [15:0] c = w[15:0];
    logic [4:0]  rd = c[11:7], r2 = c[6:2];
    logic [4:0]  pa = {2'b01, c[9:7]}, pb = {2'b01, c[4:2]};
    logic [31:0] i6 = {{26{c[12]}}, c[12], c[6:2]};
    logic [31:0] jo = {{20{c[12]}}, c[12], c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3], 1'b0};
    logic [31:0] bo = {{23{c[12]}}, c[12], c[6:5], c[2], c[11:10], c[4:3], 1'b0};
    if (w[1:0] == 2'b11) return {1'b0, w};
    case ({c[1:0], c[15:13]})
      5'b00_000: return {c[12:5] == 0, e_i({22'b0, c[10:7], c[12:11], c[5], c[6], 2'b0}, 5'd2, 3'b000, pb, 7'h13)};
      5'b00_010: return {1'b0, e_i({25'b0, c[5], c[12:10], c[6], 2'b0}, pa, 3'b010, pb, 7'h03)};
      5'b00_110: return {1'b0, e_s({25'b0, c[5], c[12:10], c[6], 2'b0}, pb, pa)};
      5'b01_000: return {1'b0, e_i(i6, rd, 3'b000, rd, 7'h13)};
      5'b01_001: return {1'b0, e_j(jo, 5'd1)};
      5'b01_010: return {1'b0, e_i(i6, 5'd0, 3'b000, rd, 7'h13)};
      5'b01_011: begin
        if ({c[12], c[6:2]} == 0) return {1'b1, 32'h0};
        if (rd == 5'd2)
          return {1'b0, e_i({{23{c[12]}}, c[12], c[4:3], c[5], c[2], c[6], 4'b0}, 5'd2, 3'b000, 5'd2, 7'h13)};
        return {1'b0, i6[19:0], rd, 7'h37};
      end
      5'b01_100: begin
        case (c[11:10])
          2'b00: return {c[12], e_r(7'h00, c[6:2], pa, 3'b101, pa, 7'h13)};
          2'b01: return {c[12], e_r(7'h20, c[6:2], pa, 3'b101, pa, 7'h13)};
          2'b10: return {1'b0, e_i(i6, pa, 3'b111, pa, 7'h13)};
          default: begin
            logic [2:0] f3 = (c[6:5] == 0) ? 3'b000 : (c[6:5] == 1) ? 3'b100 :
                             (c[6:5] == 2) ? 3'b110 : 3'b111;
            return {c[12], e_r(c[6:5] == 0 ? 7'h20 : 7'h00, pb, pa, f3, pa, 7'h33)};
          end
        endcase
      end
      5'b01_101: return {1'b0, e_j(jo, 5'd0)};
      5'b01_110: return {1'b0, e_b(bo, pa, 3'b000)};
      5'b01_111: return {1'b0, e_b(bo, pa, 3'b001)};
      5'b10_000: return {c[12], e_r(7'h00, c[6:2], rd, 3'b001, rd, 7'h13)};
      5'b10_010: return {rd == 0, e_i({24'b0, c[3:2], c[12], c[6:4], 2'b0}, 5'd2, 3'b010, rd, 7'h03)};
      5'b10_110: return {1'b0, e_s({24'b0, c[8:7], c[12:9], 2'b0}, r2, 5'd2)};
      5'b10_100: begin
        if (r2 != 0) return {1'b0, e_r(7'h00, r2, c[12] ? rd : 5'd0, 3'b000, rd, 7'h33)};
        if (!c[12]) return {rd == 0, e_i(32'd0, rd, 3'b000, 5'd0, 7'h67)};
        if (rd == 0) return {1'b0, 32'h0010_0073};
        return {1'b0, e_i(32'd0, rd, 3'b000, 5'd1, 7'h67)};
      end
      default: return {1'b1, 32'h0};
    endcase
  endfunction

  task automatic chk(input logic [31:0] w, input logic [31:0] exp_w, input logic exp_ill,
                     input string tag);
    @(posedge clk);
    instr_i = w;
    @(negedge clk);
    n_chk++;
    if (illegal_o !== exp_ill || is_compressed_o !== (w[1:0] != 2'b11) ||
        (!exp_ill && instr_o !== exp_w)) begin
      n_err++;
      $display("FAIL %s in=%08h got word=%08h ill=%0b c=%0b exp word=%08h ill=%0b",
               tag, w, instr_o, illegal_o, is_compressed_o, exp_w, exp_ill);
    end
  endtask

  task automatic chk_m(input logic [31:0] w, input string tag);
    logic [32:0] m = model(w);
    chk(w, m[31:0], m[32], tag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    n_chk++;
    if (instr_o !== 32'h0000_0013 || is_compressed_o !== 1'b0 || illegal_o !== 1'b0) begin
      n_err++;
      $display("FAIL R1 initial word got %08h exp 00000013", instr_o);
    end
    chk(32'h00B0_0533, 32'h00B0_0533, 1'b0, "R1 full-length passthrough");
    chk(32'h0000_852E, 32'h00B0_0533, 1'b0, "R3 move x10<-x11");
    chk(32'h0000_8082, 32'h0000_8067, 1'b0, "R3 jump-register x1");
    chk(32'h0000_8002, 32'h0, 1'b1, "R4 jump-register x0");
    chk(32'h0000_9002, 32'h0010_0073, 1'b0, "R5 ebreak");
    chk(32'h0000_9282, 32'h0002_80E7, 1'b0, "R5 link jump x5");
    chk(32'h0000_900E, 32'h0030_0033, 1'b0, "R6 add hint rd=x0");
    chk(32'h0000_800E, 32'h0030_0033, 1'b0, "R6 move hint rd=x0");
    chk(32'h0000_4015, 32'h0050_0013, 1'b0, "R7 load-imm hint");
    chk(32'h0000_6005, 32'h0000_1037, 1'b0, "R7 load-upper hint");
    chk(32'h0000_8001, 32'h0004_5413, 1'b0, "R7 right shift by 0 hint");
    chk(32'h0000_0006, 32'h0010_1013, 1'b0, "R7 left shift rd=x0 hint");
    chk(32'h0000_0000, 32'h0, 1'b1, "R8 all-zero half-word");
    chk(32'h0000_0004, 32'h0, 1'b1, "R8 sp add zero imm");
    chk(32'h0000_9001, 32'h0, 1'b1, "R9 right shift bit12");
    chk(32'h0000_6281, 32'h0, 1'b1, "R9 load-upper zero imm");
    chk(32'h0000_6101, 32'h0, 1'b1, "R9 stack adjust zero imm");
    chk(32'h0000_4144, 32'h0045_2483, 1'b0, "R10 R13 lw x9,4(x10)");
    chk(32'h0000_BFFD, 32'hFFFF_F06F, 1'b0, "R11 jump -2");
    chk(32'h0000_DC7D, 32'hFE04_0FE3, 1'b0, "R11 branch-zero -2");
    chk(32'h0000_2000, 32'h0, 1'b1, "R12 fp load");
    chk(32'h0000_9C21, 32'h0, 1'b1, "R12 reg group bit12");
    chk(32'h0000_4002, 32'h0, 1'b1, "R12 stack load rd=x0");
    chk_m(32'h0000_C006, "R13 stack store");
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] w = $urandom();
      if (i % 4 == 0) w[1:0] = 2'b11;
      else if (w[1:0] == 2'b11) w[1:0] = 2'b10;
      if (i % 8 == 1) begin
        w[15:13] = 3'b100; w[1:0] = 2'b10;
        if (w[20]) w[6:2] = 5'd0;
        if (w[21]) w[11:7] = 5'd0;
      end
      chk_m(w, "R2 random vs model");
    end
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 100000 && !done; t++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not finish, got timeout exp completion");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule